// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block sits next to a UART and turns its status events into one interrupt line and one receive DMA request. The events are: a received character is waiting, the transmit buffer has emptied, and the baud-rate generator has counted down to zero. An 8-bit enable register chooses which events may interrupt and whether received characters go to a DMA engine. Software writes the register through a simple write port and reads it back on a dedicated output.

When the receiver is handed to DMA, a waiting character raises a DMA request rather than an interrupt. The receive interrupt is then held back until the DMA engine reports end of process. A separate mode input tells the block whether the transmitter is also in DMA operation. If it is, the transmit interrupt is held back in the same way. The DMA request is a level that stays high until the DMA engine acknowledges it. After that it remains low until the current character has gone and a new one arrives.

The interrupt and the DMA request are both registered. Each follows its inputs one clock later. Each also follows a register write one clock after the new enable value appears at the readback output.

Top module: `uart_irq_dma_ctl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the readback value is 0x00 and both `irq` and `rx_dma_req` are low.
- R2: A write stores all 8 bits of `wr_data`. The new value appears on `rd_data` one clock after the write edge.
- R3: With enable bit 0 set and enable bit 1 clear, `rx_avail` high drives `irq` high one clock later. With bit 0 clear, `rx_avail` alone never raises `irq`.
- R4: With enable bits 0 and 1 both set, `rx_avail` raises `irq` only in cycles where `dma_eop` is also high.
- R5: With enable bit 2 set and `tx_dma_mode` low, `tx_empty` high drives `irq` high one clock later.
- R6: With enable bit 2 set and `tx_dma_mode` high, `tx_empty` raises `irq` only when `dma_eop` is also high.
- R7: With enable bit 3 set, `zero_count` high drives `irq` high one clock later. Clearing the bit removes that source.
- R8: `irq` is the registered OR of all qualified sources. It stays high while any qualified source remains, and falls one clock after the last one goes away.
- R9: With enable bit 1 set, `rx_avail` high drives `rx_dma_req` high one clock later.
- R10: `dma_ack` while `rx_dma_req` is high drops the request on the next clock. The request stays low until `rx_avail` has gone low and then high again.
- R11: With enable bit 1 clear, `rx_dma_req` is low. Clearing the bit while a request is pending drops the request.
- R12: Enable bits 7 to 4 are stored and read back, but they change neither `irq` nor `rx_dma_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the enable register |
| wr_data | input | 8 | Value to write |
| rx_avail | input | 1 | Received character waiting |
| tx_empty | input | 1 | Transmit buffer empty |
| zero_count | input | 1 | Baud-rate generator reached zero |
| dma_eop | input | 1 | DMA counter end of process |
| tx_dma_mode | input | 1 | Transmitter is in DMA operation |
| dma_ack | input | 1 | DMA engine accepts the receive request |
| irq | output | 1 | Combined interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| rd_data | output | 8 | Readback of the enable register |

## Verification
A corrupted enable bit shows up on `rd_data` one clock after the write that should have set it. It also shows up on `irq` or `rx_dma_req` one clock after that. A stuck or lost acknowledge flag shows in one of two ways. Either the request is re-raised while the same character is still waiting, or no request follows a fresh character. Both show within two clocks of the `rx_avail` edge. Wrong gating by end of process makes `irq` differ in the very next cycle after `dma_eop` changes, so every defect in this block is visible within two clocks.

// File: rtl/uirq_pkg.sv
// Package: shared constants for the UART interrupt/DMA request controller.
// Assumes an 8-bit enable register; bit positions are fixed because the
// combining logic decodes them.
package uirq_pkg;
    localparam int CTRL_W     = 8;
    localparam int EN_RX_IRQ  = 0;
    localparam int EN_RX_DMA  = 1;
    localparam int EN_TX_IRQ  = 2;
    localparam int EN_ZC_IRQ  = 3;
    localparam int N_SRC      = 3;
    localparam int SRC_RX     = 0;
    localparam int SRC_TX     = 1;
    localparam int SRC_ZC     = 2;
endpackage

// File: rtl/uirq_enable_reg.sv
// Module: enable register. It stores every written bit and presents the
// stored value continuously. Assumes one write port, no byte lanes.
module uirq_enable_reg #(
    parameter int W = uirq_pkg::CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] en_q
);
    // Capture written value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wr_data;
    end
endmodule

// File: rtl/uirq_irq_combine.sv
// Module: interrupt combiner. It qualifies each status source with its
// enable and, where DMA is active, with end of process, then registers
// the OR. Assumes the status inputs are synchronous to clk.
module uirq_irq_combine #(
    parameter int NS = uirq_pkg::N_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src,
    input  logic [NS-1:0] src_en,
    input  logic [NS-1:0] src_dma,
    input  logic          dma_eop,
    output logic          irq
);
    logic [NS-1:0] qual;

    // Per-source qualification: enable, plus end of process when in DMA.
    for (genvar i = 0; i < NS; i++) begin : g_qual
        always_comb qual[i] = src[i] & src_en[i] & (~src_dma[i] | dma_eop);
    end

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |qual;
    end
endmodule

// File: rtl/uirq_rxdma_req.sv
// Module: receive DMA request tracker. It raises a request for a waiting
// character and drops it on acknowledge. It does not re-raise the request
// until the character-available level has gone low once.
module uirq_rxdma_req (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic rx_avail,
    input  logic dma_ack,
    output logic req
);
    logic served_q;
    logic take;

    // Acknowledge counts only while a request is outstanding.
    always_comb take = dma_ack & req;

    // Remember that the current character was already taken by DMA.
    always_ff @(posedge clk) begin
        if (!rst_n)        served_q <= 1'b0;
        else if (take)     served_q <= 1'b1;
        else if (!rx_avail) served_q <= 1'b0;
    end

    // Request level: enabled, character waiting, not yet served.
    always_ff @(posedge clk) begin
        if (!rst_n) req <= 1'b0;
        else        req <= dma_en & rx_avail & ~served_q & ~take;
    end
endmodule

// File: rtl/uart_irq_dma_ctl.sv
// Module: top of the UART interrupt/DMA request controller. It ties the
// enable register to the interrupt combiner and the receive DMA tracker.
// Assumes synchronous status inputs and a single-cycle write strobe.
module uart_irq_dma_ctl
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              rx_avail,
    input  logic              tx_empty,
    input  logic              zero_count,
    input  logic              dma_eop,
    input  logic              tx_dma_mode,
    input  logic              dma_ack,
    output logic              irq,
    output logic              rx_dma_req,
    output logic [CTRL_W-1:0] rd_data
);
    logic [CTRL_W-1:0] en_q;
    logic [N_SRC-1:0]  src, src_en, src_dma;

    uirq_enable_reg #(.W(CTRL_W)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .en_q(en_q)
    );

    // Map status, enables and DMA gating onto the source vector.
    always_comb begin
        src[SRC_RX]     = rx_avail;
        src[SRC_TX]     = tx_empty;
        src[SRC_ZC]     = zero_count;
        src_en[SRC_RX]  = en_q[EN_RX_IRQ];
        src_en[SRC_TX]  = en_q[EN_TX_IRQ];
        src_en[SRC_ZC]  = en_q[EN_ZC_IRQ];
        src_dma[SRC_RX] = en_q[EN_RX_DMA];
        src_dma[SRC_TX] = tx_dma_mode;
        src_dma[SRC_ZC] = 1'b0;
    end

    uirq_irq_combine #(.NS(N_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .src(src), .src_en(src_en),
        .src_dma(src_dma), .dma_eop(dma_eop), .irq(irq)
    );

    uirq_rxdma_req u_rxdma (
        .clk(clk), .rst_n(rst_n), .dma_en(en_q[EN_RX_DMA]),
        .rx_avail(rx_avail), .dma_ack(dma_ack), .req(rx_dma_req)
    );

    // Readback of the stored enables.
    always_comb rd_data = en_q;
endmodule

// File: rtl/uirq_checker.sv
// Module: port-level checker for uart_irq_dma_ctl, attached through bind.
module uirq_checker
    import uirq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic              rx_avail,
    input logic              tx_empty,
    input logic              zero_count,
    input logic              dma_eop,
    input logic              tx_dma_mode,
    input logic              dma_ack,
    input logic              irq,
    input logic              rx_dma_req,
    input logic [CTRL_W-1:0] rd_data
);
    logic any_src;
    always_comb any_src =
        (rx_avail & rd_data[EN_RX_IRQ] & (~rd_data[EN_RX_DMA] | dma_eop)) |
        (tx_empty & rd_data[EN_TX_IRQ] & (~tx_dma_mode | dma_eop)) |
        (zero_count & rd_data[EN_ZC_IRQ]);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !irq && !rx_dma_req));
    p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));
    p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> irq);
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_src |=> !irq);
    p_req_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dma_req) |-> $past(rx_avail));
    p_req_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_req && dma_ack) |=> !rx_dma_req);
    p_req_enable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[EN_RX_DMA] |=> !rx_dma_req);
endmodule

bind uart_irq_dma_ctl uirq_checker u_chk (.*);

// File: tb/uart_irq_dma_ctl_tb.sv
`timescale 1ns/1ps
module uart_irq_dma_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rx_avail = 1'b0, tx_empty = 1'b0, zero_count = 1'b0;
    logic       dma_eop = 1'b0, tx_dma_mode = 1'b0, dma_ack = 1'b0;
    logic       irq, rx_dma_req;
    logic [7:0] rd_data;
    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_irq_dma_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rx_avail(rx_avail), .tx_empty(tx_empty), .zero_count(zero_count),
        .dma_eop(dma_eop), .tx_dma_mode(tx_dma_mode), .dma_ack(dma_ack),
        .irq(irq), .rx_dma_req(rx_dma_req), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        cyc();
        wr_en = 1'b0;
        cyc();
    endtask

    task automatic idle_inputs();
        rx_avail = 0; tx_empty = 0; zero_count = 0;
        dma_eop = 0; tx_dma_mode = 0; dma_ack = 0;
        wr(8'h00);
    endtask

    task automatic t_reset();
        cyc(); cyc();
        chk("R1 reg in reset", rd_data, 8'h00);
        chk("R1 irq in reset", {7'b0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc();
        chk("R1 reg after reset", rd_data, 8'h00);
        chk("R1 req after reset", {7'b0, rx_dma_req}, 8'h00);
    endtask

    task automatic t_write();
        wr_en = 1'b1; wr_data = 8'hA5;
        cyc();
        wr_en = 1'b0;
        chk("R2 readback A5", rd_data, 8'hA5);
        wr(8'h5A);
        chk("R2 readback 5A", rd_data, 8'h5A);
        wr(8'h00);
    endtask

    task automatic t_rx_irq();
        wr(8'h01);
        rx_avail = 1; cyc();
        chk("R3 rx irq", {7'b0, irq}, 8'h01);
        rx_avail = 0; cyc();
        chk("R3 rx irq falls", {7'b0, irq}, 8'h00);
        wr(8'h00);
        rx_avail = 1; cyc();
        chk("R3 rx disabled", {7'b0, irq}, 8'h00);
        idle_inputs();
    endtask

    task automatic t_rx_dma();
        wr(8'h03);
        rx_avail = 1; cyc();
        chk("R4 held without eop", {7'b0, irq}, 8'h00);
        chk("R9 req raised", {7'b0, rx_dma_req}, 8'h01);
        dma_eop = 1; cyc();
        chk("R4 irq with eop", {7'b0, irq}, 8'h01);
        dma_ack = 1; cyc(); dma_ack = 0;
        chk("R10 req dropped", {7'b0, rx_dma_req}, 8'h00);
        cyc();
        chk("R10 req stays low", {7'b0, rx_dma_req}, 8'h00);
        dma_eop = 0; rx_avail = 0; cyc();
        rx_avail = 1; cyc();
        chk("R10 req on new char", {7'b0, rx_dma_req}, 8'h01);
        idle_inputs();
    endtask

    task automatic t_rx_dma_off();
        wr(8'h02);
        rx_avail = 1; cyc();
        chk("R11 req pending", {7'b0, rx_dma_req}, 8'h01);
        wr(8'h00);
        chk("R11 req dropped by disable", {7'b0, rx_dma_req}, 8'h00);
        idle_inputs();
    endtask

    task automatic t_tx();
        wr(8'h04);
        tx_empty = 1; cyc();
        chk("R5 tx irq", {7'b0, irq}, 8'h01);
        tx_dma_mode = 1; cyc();
        chk("R6 tx held", {7'b0, irq}, 8'h00);
        dma_eop = 1; cyc();
        chk("R6 tx with eop", {7'b0, irq}, 8'h01);
        idle_inputs();
    endtask

    task automatic t_zc();
        wr(8'h08);
        zero_count = 1; cyc();
        chk("R7 zc irq", {7'b0, irq}, 8'h01);
        wr(8'h00);
        chk("R7 zc disabled", {7'b0, irq}, 8'h00);
        idle_inputs();
    endtask

    task automatic t_or();
        wr(8'h0D);
        rx_avail = 1; tx_empty = 1; cyc();
        chk("R8 two sources", {7'b0, irq}, 8'h01);
        rx_avail = 0; cyc();
        chk("R8 one remains", {7'b0, irq}, 8'h01);
        tx_empty = 0; zero_count = 1; cyc();
        chk("R8 handover", {7'b0, irq}, 8'h01);
        zero_count = 0; cyc();
        chk("R8 all gone", {7'b0, irq}, 8'h00);
        idle_inputs();
    endtask

    task automatic t_upper();
        wr(8'hF0);
        chk("R12 upper readback", rd_data, 8'hF0);
        rx_avail = 1; tx_empty = 1; zero_count = 1; dma_eop = 1; cyc();
        chk("R12 no irq", {7'b0, irq}, 8'h00);
        chk("R12 no req", {7'b0, rx_dma_req}, 8'h00);
        idle_inputs();
    endtask

    initial begin : main
        t_reset();
        t_write();
        t_rx_irq();
        t_rx_dma();
        t_rx_dma_off();
        t_tx();
        t_zc();
        t_or();
        t_upper();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : watchdog
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule